// File: doc/BRIEF.md
# Adapter Host Register Interface

This block is the host-facing system register set of an add-on processor adapter. The host bus is 16 bits wide and supports byte and word reads and writes. The block decodes the low 16 bits of the host's system-register page. A 64-byte register window at offset 0x5100 holds the following:
- a control word that enables the adapter and governs the slave processors' reset line,
- a DMA request length register,
- a 16-byte mailbox area that the host and the adapter share.

A read-only four-character identity window sits at offset 0x30EC.

Register writability has two phases. While the adapter is disabled, the host may write only the mailbox area and the enable bit. Once the adapter is enabled, the control fields and the length register become writable. From then on, host accesses that fall outside the adapter's 1 KiB sub-page are passed straight through to an external I/O port. The block also produces two single-cycle strobes: an adapter-startup strobe and a slave-processor reset strobe. The surrounding adapter logic consumes both.

Top module: `adp_sysreg`

## Requirements
- R1: After reset the control word (window offset 0x00) reads 0x0082. Bit 0 is enable (0), bit 1 is the active-low slave reset (1), bit 7 is the read-only reset-enable status (1) and bit 15 is bus-access select (0). The length register reads 0 and both strobes are low.
- R2: While enable is clear, the following writes leave every register unchanged: writes to the control word that do not set enable, byte writes to control offset 0x00, writes to the length register, and writes to other window offsets.
- R3: A write that sets enable is either a byte write to offset 0x01 with data bit 0 set, or a word write to offset 0x00 with bit 0 set. Such a write sets enable for good and raises `adapter_startup` for exactly the next cycle. It clears the reset bit and then loads it from data bit 1. If that bit is 1, `slave_reset` pulses in the same cycle as the startup strobe. A word write of this kind also loads bus-access select from bit 15. No later write clears enable.
- R4: With enable set, a write that takes the reset bit from 0 to 1 raises `slave_reset` for exactly one cycle, the cycle after the write. A write that leaves the bit at 1 or clears it produces no strobe.
- R5: With enable set, the control fields update as follows. A byte write to offset 0x00 changes only bus-access select, from data bit 7. A byte write to offset 0x01 changes only the reset bit, from data bit 1. A word write to offset 0x00 changes both, from bits 15 and 1. The status bit always reads 1.
- R6: The length register at offset 0x10 is writable only with enable set, and its bits 1:0 always read 0.
- R7: The identity window at 0x30EC–0x30EF reads as words 0x4D41 and 0x5253, and as bytes 0x4D, 0x41, 0x52, 0x53 in address order.
- R8: In a byte access the even address selects bits 15:8 and the odd address selects bits 7:0. A byte read returns the lane in bits 7:0 with bits 15:8 zero. A byte write takes its data from bits 7:0 and leaves the other lane unchanged.
- R9: The mailbox area at window offsets 0x20–0x2F is readable and writable in both phases. It powers up to zero and keeps its contents through reset.
- R10: With enable set, any access outside 0x5000–0x53FF that is not in the identity window drives `io_req` in the same cycle, with address, write flag, size and write data passed unchanged. A read of this kind returns `io_rdata` unchanged. While enable is clear, `io_req` stays low.
- R11: A read of an address that no region claims returns zero and raises `bus_unmapped` together with `bus_rvalid` for one cycle. This covers everything outside the window and the identity window while disabled, and non-window addresses inside 0x5000–0x53FF while enabled.
- R12: Every read gives `bus_rvalid` for exactly the cycle after the request. Window offsets with no register read zero and are not flagged as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Host access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_addr | input | 16 | Offset within the system-register page |
| bus_wdata | input | 16 | Write data (bits 7:0 for byte writes) |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, cycle after a read request |
| bus_unmapped | output | 1 | Read hit no mapped region |
| io_req | output | 1 | Forwarded access request |
| io_we | output | 1 | Forwarded write flag |
| io_byte | output | 1 | Forwarded access size |
| io_addr | output | 16 | Forwarded address |
| io_wdata | output | 16 | Forwarded write data |
| io_rdata | input | 16 | Read data from the external I/O port |
| slave_reset | output | 1 | One-cycle slave-processor reset strobe |
| adapter_startup | output | 1 | One-cycle adapter startup strobe |

## Verification
The assertions assume that the host raises `bus_req` only for single-cycle accesses and that it holds `bus_req` low while reset is asserted. They also assume that word accesses use even addresses. The stimulus drives one access per cycle and clears the request during every reset. It rounds each random word address down to even. It samples `io_rdata` from a bench function of the forwarded address, so forwarded reads have a predictable value.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int BUS_W = 16;

  // control word bit positions (the host software decodes these)
  localparam int CTL_ADEN = 0;
  localparam int CTL_NRES = 1;
  localparam int CTL_REN  = 7;
  localparam int CTL_FM   = 15;

  localparam logic [BUS_W-1:0] ID_FIRST  = 16'h4D41;
  localparam logic [BUS_W-1:0] ID_SECOND = 16'h5253;

  typedef enum logic [1:0] {
    RG_WIN  = 2'd0,
    RG_ID   = 2'd1,
    RG_IO   = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    WS_CTRL  = 2'd0,
    WS_DREQ  = 2'd1,
    WS_COMM  = 2'd2,
    WS_OTHER = 2'd3
  } winsel_e;
endpackage

// File: rtl/adp_decode.sv
module adp_decode
  import adp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WIN_BASE   = 'h5100,
  parameter int WIN_BYTES  = 64,
  parameter int SUB_BASE   = 'h5000,
  parameter int SUB_BYTES  = 1024,
  parameter int ID_BASE    = 'h30EC,
  parameter int DREQ_OFF   = 'h10,
  parameter int COMM_OFF   = 'h20,
  parameter int COMM_BYTES = 16
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                aden,
  output region_e                             region,
  output winsel_e                             winsel,
  output logic [$clog2(COMM_BYTES/2)-1:0]     comm_idx
);
  localparam int WIN_IDX_W  = $clog2(WIN_BYTES);
  localparam int COMM_IDX_W = $clog2(COMM_BYTES/2);
  localparam int ID_BYTES   = 4;

  localparam logic [ADDR_W-1:0] WIN_B   = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_LIM = ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] SUB_B   = ADDR_W'(SUB_BASE);
  localparam logic [ADDR_W-1:0] SUB_LIM = ADDR_W'(SUB_BYTES);
  localparam logic [ADDR_W-1:0] ID_B    = ADDR_W'(ID_BASE);
  localparam logic [ADDR_W-1:0] ID_LIM  = ADDR_W'(ID_BYTES);

  localparam logic [WIN_IDX_W-1:0] DREQ_O = WIN_IDX_W'(DREQ_OFF);
  localparam logic [WIN_IDX_W-1:0] COMM_O = WIN_IDX_W'(COMM_OFF);
  localparam logic [WIN_IDX_W:0]   COMM_E = (WIN_IDX_W+1)'(COMM_OFF + COMM_BYTES);

  logic [ADDR_W-1:0]    rel_win, rel_sub, rel_id;
  logic                 in_win, in_sub, in_id;
  logic [WIN_IDX_W-1:0] win_off;

  assign rel_win = addr - WIN_B;
  assign rel_sub = addr - SUB_B;
  assign rel_id  = addr - ID_B;
  assign in_win  = rel_win < WIN_LIM;
  assign in_sub  = rel_sub < SUB_LIM;
  assign in_id   = rel_id  < ID_LIM;
  assign win_off = rel_win[WIN_IDX_W-1:0];

  // mailbox is aligned to its own size, so the low offset bits index it
  assign comm_idx = win_off[COMM_IDX_W:1];

  always_comb begin
    if (in_id)
      region = RG_ID;
    else if (in_win)
      region = RG_WIN;
    else if (aden && !in_sub)
      region = RG_IO;
    else
      region = RG_NONE;
  end

  always_comb begin
    if (win_off[WIN_IDX_W-1:1] == '0)
      winsel = WS_CTRL;
    else if (win_off[WIN_IDX_W-1:1] == DREQ_O[WIN_IDX_W-1:1])
      winsel = WS_DREQ;
    else if (win_off >= COMM_O && {1'b0, win_off} < COMM_E)
      winsel = WS_COMM;
    else
      winsel = WS_OTHER;
  end
endmodule

// File: rtl/adp_ctrl_reg.sv
module adp_ctrl_reg
  import adp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             byte_acc,
  input  logic             odd,
  input  logic             d_fm_word,
  input  logic             d_fm_byte,
  input  logic             d_nres,
  input  logic             d_aden,
  output logic [BUS_W-1:0] ctrl_word,
  output logic             aden,
  output logic             slave_reset,
  output logic             startup
);
  logic fm_q, nres_q, aden_q;
  logic fm_d, nres_d, aden_d, rst_d, st_d;
  logic take_en;

  always_comb begin
    fm_d    = fm_q;
    nres_d  = nres_q;
    aden_d  = aden_q;
    rst_d   = 1'b0;
    st_d    = 1'b0;
    take_en = byte_acc ? (odd & d_aden) : d_aden;
    if (wr) begin
      if (!aden_q) begin
        // locked phase: only the enable bit is honoured
        if (take_en) begin
          aden_d = 1'b1;
          st_d   = 1'b1;
          nres_d = d_nres;          // reset bit forced low, then loaded
          rst_d  = d_nres;
          if (!byte_acc)
            fm_d = d_fm_word;
        end
      end else begin
        if (!byte_acc) begin
          fm_d   = d_fm_word;
          nres_d = d_nres;
        end else if (!odd) begin
          fm_d = d_fm_byte;
        end else begin
          nres_d = d_nres;
        end
        rst_d = !nres_q && nres_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fm_q        <= 1'b0;
      nres_q      <= 1'b1;
      aden_q      <= 1'b0;
      slave_reset <= 1'b0;
      startup     <= 1'b0;
    end else begin
      fm_q        <= fm_d;
      nres_q      <= nres_d;
      aden_q      <= aden_d;
      slave_reset <= rst_d;
      startup     <= st_d;
    end
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CTL_ADEN] = aden_q;
    ctrl_word[CTL_NRES] = nres_q;
    ctrl_word[CTL_REN]  = 1'b1;
    ctrl_word[CTL_FM]   = fm_q;
  end

  assign aden = aden_q;

  a_r3_aden_sticky: assert property (@(posedge clk) disable iff (rst)
    aden_q |=> aden_q);
  a_r3_startup_once: assert property (@(posedge clk) disable iff (rst)
    startup |-> (aden_q && !$past(aden_q)));
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
    slave_reset |=> !slave_reset);
  a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
    slave_reset |-> (nres_q && (startup || !$past(nres_q))));
  a_r2_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    !aden_q |-> (!fm_q && nres_q));
endmodule

// File: rtl/adp_comm_ram.sv
module adp_comm_ram #(
  parameter int WORDS = 8,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       we_hi,
  input  logic                       we_lo,
  input  logic [$clog2(WORDS)-1:0]   addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++)
      mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we_hi)
      mem[addr][DW-1:HALF] <= wdata[DW-1:HALF];
    if (we_lo)
      mem[addr][HALF-1:0] <= wdata[HALF-1:0];
    rdata <= mem[addr];
  end
endmodule

// File: rtl/adp_sysreg.sv
module adp_sysreg
  import adp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WIN_BASE   = 'h5100,
  parameter int WIN_BYTES  = 64,
  parameter int SUB_BASE   = 'h5000,
  parameter int SUB_BYTES  = 1024,
  parameter int ID_BASE    = 'h30EC,
  parameter int DREQ_OFF   = 'h10,
  parameter int COMM_OFF   = 'h20,
  parameter int COMM_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_unmapped,
  output logic              io_req,
  output logic              io_we,
  output logic              io_byte,
  output logic [ADDR_W-1:0] io_addr,
  output logic [15:0]       io_wdata,
  input  logic [15:0]       io_rdata,
  output logic              slave_reset,
  output logic              adapter_startup
);
  localparam int COMM_WORDS = COMM_BYTES / 2;
  localparam int COMM_IDX_W = $clog2(COMM_WORDS);
  localparam int HALF       = BUS_W / 2;

  region_e               region;
  winsel_e               winsel;
  logic [COMM_IDX_W-1:0] comm_idx;
  logic                  aden;
  logic [BUS_W-1:0]      ctrl_word;
  logic [BUS_W-1:0]      dreq_q;
  logic [BUS_W-1:0]      lane_data;
  logic [BUS_W-1:0]      comm_q;
  logic                  rd, wr, win_wr, lane_hi, lane_lo;
  logic                  ctrl_wr, dreq_wr, comm_wr;

  adp_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
    .SUB_BASE(SUB_BASE), .SUB_BYTES(SUB_BYTES), .ID_BASE(ID_BASE),
    .DREQ_OFF(DREQ_OFF), .COMM_OFF(COMM_OFF), .COMM_BYTES(COMM_BYTES)
  ) u_decode (
    .addr(bus_addr), .aden(aden), .region(region), .winsel(winsel),
    .comm_idx(comm_idx)
  );

  assign rd        = bus_req && !bus_we;
  assign wr        = bus_req && bus_we;
  assign win_wr    = wr && (region == RG_WIN);
  assign lane_hi   = !bus_byte || !bus_addr[0];
  assign lane_lo   = !bus_byte || bus_addr[0];
  assign lane_data = bus_byte ? {bus_wdata[HALF-1:0], bus_wdata[HALF-1:0]} : bus_wdata;
  assign ctrl_wr   = win_wr && (winsel == WS_CTRL);
  assign dreq_wr   = win_wr && (winsel == WS_DREQ) && aden;
  assign comm_wr   = win_wr && (winsel == WS_COMM);

  adp_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .byte_acc(bus_byte), .odd(bus_addr[0]),
    .d_fm_word(bus_wdata[CTL_FM]), .d_fm_byte(bus_wdata[HALF-1]),
    .d_nres(bus_wdata[CTL_NRES]), .d_aden(bus_wdata[CTL_ADEN]),
    .ctrl_word(ctrl_word), .aden(aden), .slave_reset(slave_reset),
    .startup(adapter_startup)
  );

  // length register: low two bits never stored
  always_ff @(posedge clk) begin
    if (rst) begin
      dreq_q <= '0;
    end else if (dreq_wr) begin
      if (lane_hi)
        dreq_q[BUS_W-1:HALF] <= lane_data[BUS_W-1:HALF];
      if (lane_lo)
        dreq_q[HALF-1:0] <= {lane_data[HALF-1:2], 2'b00};
    end
  end

  adp_comm_ram #(.WORDS(COMM_WORDS), .DW(BUS_W)) u_comm (
    .clk(clk), .we_hi(comm_wr && lane_hi), .we_lo(comm_wr && lane_lo),
    .addr(comm_idx), .wdata(lane_data), .rdata(comm_q)
  );

  // pass-through port
  assign io_req   = bus_req && (region == RG_IO);
  assign io_we    = bus_we;
  assign io_byte  = bus_byte;
  assign io_addr  = bus_addr;
  assign io_wdata = bus_wdata;

  // read return path
  logic [BUS_W-1:0] side_d, side_q, word_q;
  logic             r_valid, r_unm, r_comm, r_raw, r_byte, r_hi, r_dreq;

  always_comb begin
    side_d = '0;
    case (region)
      RG_WIN: begin
        if (winsel == WS_CTRL)
          side_d = ctrl_word;
        else if (winsel == WS_DREQ)
          side_d = dreq_q;
      end
      RG_ID:   side_d = bus_addr[1] ? ID_SECOND : ID_FIRST;
      RG_IO:   side_d = io_rdata;
      default: side_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid <= 1'b0;
      r_unm   <= 1'b0;
      r_comm  <= 1'b0;
      r_raw   <= 1'b0;
      r_byte  <= 1'b0;
      r_hi    <= 1'b0;
      r_dreq  <= 1'b0;
      side_q  <= '0;
    end else begin
      r_valid <= rd;
      r_unm   <= rd && (region == RG_NONE);
      r_comm  <= rd && (region == RG_WIN) && (winsel == WS_COMM);
      r_raw   <= rd && (region == RG_IO);
      r_byte  <= bus_byte;
      r_hi    <= !bus_addr[0];
      r_dreq  <= rd && (region == RG_WIN) && (winsel == WS_DREQ) && lane_lo;
      side_q  <= rd ? side_d : '0;
    end
  end

  assign word_q = r_comm ? comm_q : side_q;

  always_comb begin
    if (!r_valid)
      bus_rdata = '0;
    else if (r_raw || !r_byte)
      bus_rdata = word_q;
    else
      bus_rdata = {{HALF{1'b0}}, r_hi ? word_q[BUS_W-1:HALF] : word_q[HALF-1:0]};
  end

  assign bus_rvalid   = r_valid;
  assign bus_unmapped = r_unm;

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    bus_unmapped |-> (bus_rvalid && bus_rdata == '0));
  a_r10_io_only_enabled: assert property (@(posedge clk) disable iff (rst)
    io_req |-> aden);
  a_r6_dreq_low_clear: assert property (@(posedge clk) disable iff (rst)
    r_dreq |-> (bus_rdata[1:0] == 2'b00));
  a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);
endmodule

// File: tb/adp_sysreg_tb.sv
module adp_sysreg_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we, bus_byte;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_rvalid, bus_unmapped;
  logic        io_req, io_we, io_byte;
  logic [15:0] io_addr, io_wdata, io_rdata;
  logic        slave_reset, adapter_startup;

  always #5 clk = ~clk;

  assign io_rdata = io_addr ^ 16'hA5C3;

  adp_sysreg u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_unmapped(bus_unmapped), .io_req(io_req),
    .io_we(io_we), .io_byte(io_byte), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .slave_reset(slave_reset), .adapter_startup(adapter_startup)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model
  logic       m_aden, m_fm, m_nres;
  logic [15:0] m_dreq;
  logic [7:0]  m_comm [16];

  function automatic int route(logic [15:0] a);
    if (a >= 16'h30EC && a <= 16'h30EF) return 1;
    if (a >= 16'h5100 && a < 16'h5140) return 0;
    if (m_aden && (a < 16'h5000 || a >= 16'h5400)) return 2;
    return 3;
  endfunction

  function automatic logic [15:0] model_word(logic [15:0] a);
    logic [15:0] off;
    logic [5:0]  o;
    off = a - 16'h5100;
    o   = off[5:0];
    case (route(a))
      0: begin
        if (o[5:1] == 5'd0) return {m_fm, 7'b0, 1'b1, 5'b0, m_nres, m_aden};
        if (o[5:1] == 5'd8) return m_dreq;
        if (o >= 6'h20 && o < 6'h30)
          return {m_comm[{o[3:1], 1'b0}], m_comm[{o[3:1], 1'b1}]};
        return 16'h0;
      end
      1: return a[1] ? 16'h5253 : 16'h4D41;
      2: return a ^ 16'hA5C3;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] model_read(logic [15:0] a, logic byt);
    logic [15:0] w;
    w = model_word(a);
    if (byt && route(a) != 2) return {8'h00, a[0] ? w[7:0] : w[15:8]};
    return w;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic byt, input logic [15:0] d,
                             output logic er, output logic es);
    logic [15:0] off;
    logic [5:0]  o;
    logic        take, old;
    er  = 1'b0;
    es  = 1'b0;
    off = a - 16'h5100;
    o   = off[5:0];
    if (route(a) != 0) return;
    if (o[5:1] == 5'd0) begin
      if (!m_aden) begin
        take = byt ? (o[0] & d[0]) : d[0];
        if (take) begin
          m_aden = 1'b1; es = 1'b1; m_nres = d[1]; er = d[1];
          if (!byt) m_fm = d[15];
        end
      end else begin
        old = m_nres;
        if (!byt) begin m_fm = d[15]; m_nres = d[1]; end
        else if (!o[0]) m_fm = d[7];
        else m_nres = d[1];
        er = !old && m_nres;
      end
    end else if (o[5:1] == 5'd8) begin
      if (m_aden) begin
        if (!byt) m_dreq = d & 16'hFFFC;
        else if (!o[0]) m_dreq[15:8] = d[7:0];
        else m_dreq[7:0] = d[7:0] & 8'hFC;
      end
    end else if (o >= 6'h20 && o < 6'h30) begin
      if (!byt) begin
        m_comm[{o[3:1], 1'b0}] = d[15:8];
        m_comm[{o[3:1], 1'b1}] = d[7:0];
      end else begin
        m_comm[o[3:0]] = d[7:0];
      end
    end
  endtask

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
    bus_addr = 16'h0; bus_wdata = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_aden = 1'b0; m_fm = 1'b0; m_nres = 1'b1; m_dreq = 16'h0;
  endtask

  task automatic do_write(logic [15:0] a, logic byt, logic [15:0] d, string tag);
    logic er, es;
    int   r;
    r = route(a);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_byte = byt; bus_addr = a; bus_wdata = d;
    #1;
    check("R10", "io_req on write", {15'h0, io_req}, {15'h0, r == 2});
    if (r == 2) begin
      check("R10", "io_we", {15'h0, io_we}, 16'h1);
      check("R10", "io_wdata", io_wdata, d);
    end
    model_write(a, byt, d, er, es);
    @(posedge clk);
    #1;
    check(tag, "slave_reset", {15'h0, slave_reset}, {15'h0, er});
    check(tag, "adapter_startup", {15'h0, adapter_startup}, {15'h0, es});
    @(negedge clk);
    bus_req = 1'b0;
    @(posedge clk);
    #1;
    check("R3/R4", "strobes single cycle", {14'h0, slave_reset, adapter_startup}, 16'h0);
  endtask

  task automatic do_read(logic [15:0] a, logic byt, string tag);
    logic [15:0] exp;
    int          r;
    r   = route(a);
    exp = model_read(a, byt);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_byte = byt; bus_addr = a;
    #1;
    check("R10", "io_req on read", {15'h0, io_req}, {15'h0, r == 2});
    @(posedge clk);
    #1;
    check("R12", "rvalid", {15'h0, bus_rvalid}, 16'h1);
    check(tag, "rdata", bus_rdata, exp);
    check("R11", "unmapped flag", {15'h0, bus_unmapped}, {15'h0, r == 3});
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, d;
    logic        byt, we;
    int          k;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_comm[i] = 8'h00;
    rst = 1'b1;
    do_reset();

    // R1 reset state
    do_read(16'h5100, 1'b0, "R1");
    do_read(16'h5110, 1'b0, "R1");
    do_read(16'h5122, 1'b0, "R9");
    @(negedge clk);
    check("R1", "strobes after reset", {14'h0, slave_reset, adapter_startup}, 16'h0);
    check("R1", "control word value", model_word(16'h5100), 16'h0082);

    // R2 locked phase
    do_write(16'h5100, 1'b0, 16'h8000, "R2");
    do_read(16'h5100, 1'b0, "R2");
    do_write(16'h5100, 1'b1, 16'h00FF, "R2");
    do_write(16'h5101, 1'b1, 16'h0000, "R2");
    do_read(16'h5100, 1'b0, "R2");
    do_write(16'h5110, 1'b0, 16'h1234, "R2");
    do_read(16'h5110, 1'b0, "R2");
    do_write(16'h5104, 1'b0, 16'hFFFF, "R2");
    do_read(16'h5104, 1'b0, "R12");

    // R9 / R8 mailbox before enable
    do_write(16'h5120, 1'b0, 16'hBEEF, "R9");
    do_write(16'h512F, 1'b1, 16'h005A, "R9");
    do_read(16'h5120, 1'b0, "R9");
    do_read(16'h5120, 1'b1, "R8");
    do_read(16'h5121, 1'b1, "R8");
    do_read(16'h512E, 1'b0, "R8");

    // R7 identity
    do_read(16'h30EC, 1'b0, "R7");
    do_read(16'h30EE, 1'b0, "R7");
    for (int i = 0; i < 4; i++) do_read(16'h30EC + 16'(i), 1'b1, "R7");

    // R10/R11 before enable
    do_read(16'h4000, 1'b0, "R11");
    do_read(16'h5180, 1'b0, "R11");

    // R3 enable via byte write, reset bit 0
    do_write(16'h5101, 1'b1, 16'h0001, "R3");
    do_read(16'h5100, 1'b0, "R3");
    check("R3", "enable-with-clear value", model_word(16'h5100), 16'h0081);

    // R3 enable cannot be cleared; R4/R5 field updates
    do_write(16'h5100, 1'b0, 16'h0000, "R3");
    do_read(16'h5100, 1'b0, "R3");
    do_write(16'h5100, 1'b0, 16'h0002, "R4");
    do_write(16'h5100, 1'b0, 16'h0002, "R4");
    do_write(16'h5101, 1'b1, 16'h0000, "R4");
    do_write(16'h5100, 1'b1, 16'h0080, "R5");
    do_read(16'h5100, 1'b0, "R5");
    do_write(16'h5101, 1'b1, 16'h0002, "R4");
    do_read(16'h5100, 1'b0, "R5");
    do_read(16'h5100, 1'b1, "R5");
    do_read(16'h5101, 1'b1, "R5");

    // R6 length register
    do_write(16'h5110, 1'b0, 16'hFFFF, "R6");
    do_read(16'h5110, 1'b0, "R6");
    do_write(16'h5111, 1'b1, 16'h0007, "R6");
    do_read(16'h5110, 1'b0, "R6");
    do_write(16'h5110, 1'b1, 16'h0012, "R8");
    do_read(16'h5110, 1'b0, "R6");
    do_read(16'h5111, 1'b1, "R6");

    // R10 forwarding, R11 sub-page gaps
    do_read(16'h4000, 1'b0, "R10");
    do_read(16'h2001, 1'b1, "R10");
    do_write(16'h2000, 1'b0, 16'h1234, "R10");
    do_read(16'h5180, 1'b0, "R11");
    do_read(16'h30ED, 1'b1, "R7");

    // random mix
    for (int i = 0; i < 400; i++) begin
      k = int'($urandom % 8);
      case (k)
        0, 1, 2, 3, 4: a = 16'h5100 + 16'($urandom % 64);
        5:             a = 16'h30EC + 16'($urandom % 4);
        6:             a = 16'($urandom) & 16'h3FFF;
        default:       a = 16'h5180 + 16'($urandom % 64);
      endcase
      byt = 1'($urandom % 2);
      we  = 1'($urandom % 2);
      d   = 16'($urandom);
      if (!byt) a[0] = 1'b0;
      if (we) do_write(a, byt, d, "R5/R9");
      else    do_read(a, byt, "R8/R9");
    end

    // R3 word enable with reset bit set; R9 retention across reset
    do_reset();
    do_read(16'h5100, 1'b0, "R1");
    do_read(16'h5120, 1'b0, "R9");
    do_write(16'h5100, 1'b0, 16'h8003, "R3");
    do_read(16'h5100, 1'b0, "R3");
    check("R3", "word enable value", model_word(16'h5100), 16'h8083);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule